// File: doc/BRIEF.md
# Pipelined-Write Flow-Through Synchronous SRAM

This block is a synchronous single-port memory that takes one new read or write command on every clock edge, in any mix, with no turnaround cycles between a read and a write. Address and control are registered on the rising edge. Read data then flows combinationally from the array to the data output during the cycle that follows that edge. Write data and byte-lane enables belong to the cycle after their command. They are sampled on the next enabled edge into a one-entry pending buffer, and that buffer is committed to the array on the enabled edge after that.

A read whose address matches the pending buffer returns the buffered lanes merged over the array word. Commands are started with a load, which checks three chip selects. A burst then continues with advance commands that step a 2-bit beat counter in linear or interleaved order. A clock enable freezes the whole pipeline.

The data bus is split into an input word, an output word and a driver enable for an external pad. The driver enable is low during every write data phase, during deselects, and whenever the asynchronous output enable is low. The default depth is 1024 words. Set `AW` to 16 for a 64K-word part.

Top module: `pwsram_top`

## Requirements
- R1: A load with all selects active and `wr`=0, taken on an enabled edge, is a read. During the next cycle, `dq_o` holds the word at `addr` and `dq_oe` is high when `oe` is high.
- R2: When `cen` is low, the edge is ignored. No input is captured, no pending write is committed, and `dq_o` and the command state stay unchanged, which stretches the current data phase.
- R3: A load is accepted only when `cs0`=1, `cs1`=1 and `cs2_n`=0. Any other combination is a deselect, and `dq_oe` stays low for the following cycle.
- R4: A load with `wr`=1 is a write. `dq_i` and `lane_we` are sampled on the next enabled edge. `lane_we[i]`=1 writes bits [8i+7:8i], and lanes whose bit is 0 keep their old contents.
- R5: During the data phase of every write, `dq_oe` is low whatever the level of `oe`.
- R6: `oe` low forces `dq_oe` low within the same cycle, with no clock edge involved.
- R7: A read of the address held in the pending write buffer returns the buffered lanes merged over the array word. This also holds for two writes to the same address in a row.
- R8: With `ilv_order`=0, beat n of a burst uses low address bits (start + n) mod 4. The upper address bits stay fixed, and the sequence wraps after four beats.
- R9: With `ilv_order`=1, beat n of a burst uses low address bits start XOR n. The upper address bits stay fixed.
- R10: An advance (`burst_load`=0) ignores `wr` and the chip selects. It keeps the direction of its burst's load. After a deselect or a reset, an advance stays deselected.
- R11: Reads and writes in any order run back to back, one data word per clock, with no idle cycles.
- R12: After reset, no access is active, no write is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen | input | 1 | Clock enable; low freezes the pipeline |
| burst_load | input | 1 | 1 = load a new command, 0 = advance the burst |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 = write, 0 = read (used on loads) |
| addr | input | AW | Word address (used on loads) |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_we | input | DW/8 | Byte-lane write enables, sampled with write data |
| dq_i | input | DW | Write data from the bus |
| oe | input | 1 | Asynchronous output enable |
| dq_o | output | DW | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench aims at read-after-write through the pending buffer. It reads an address in the cycle right after writing it, and again after two partial writes to that address. A design without the merge returns stale lanes. Every lane mask is swept, so a lane decoded to the wrong bits shows up as corrupted bytes.

Each burst start, in both orders, is written by burst and then read back by single loads. A swapped or wrapped-wrong sequencer then puts data at the wrong words. Advances are issued with wrong direction and deselected chip selects to show that they are ignored. Stalls with garbage inputs must leave the data phase untouched, and an advance after a deselect must not drive the bus.

// File: rtl/pwsram_pkg.sv
package pwsram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } beat_order_e;

  // Low two address bits for beat n of a burst
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input beat_order_e ord);
    logic [1:0] r;
    if (ord == ORD_XOR) r = start ^ n;
    else                r = start + n;
    return r;
  endfunction

endpackage

// File: rtl/pwsram_burst.sv
module pwsram_burst #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen,
  input  logic          load,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          ilv,
  output logic          acc_valid,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr
);
  import pwsram_pkg::*;

  localparam int HI_W = AW - 2;

  logic            active;
  logic            bwr;
  logic [AW-1:0]   base;
  logic [1:0]      cnt;
  logic [1:0]      cnt_nx;
  logic [1:0]      low_nx;
  logic [HI_W-1:0] base_hi;

  assign cnt_nx  = cnt + 2'd1;
  assign base_hi = base[AW-1:2];
  assign low_nx  = beat_low(base[1:0], cnt_nx, beat_order_e'(ilv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bwr       <= 1'b0;
      base      <= '0;
      cnt       <= '0;
      acc_valid <= 1'b0;
      acc_wr    <= 1'b0;
      acc_addr  <= '0;
    end else if (cen) begin
      if (load) begin
        if (sel) begin
          active    <= 1'b1;
          bwr       <= wr;
          base      <= addr;
          cnt       <= '0;
          acc_valid <= 1'b1;
          acc_wr    <= wr;
          acc_addr  <= addr;
        end else begin
          active    <= 1'b0;
          acc_valid <= 1'b0;
          acc_wr    <= 1'b0;
        end
      end else if (active) begin
        cnt       <= cnt_nx;
        acc_valid <= 1'b1;
        acc_wr    <= bwr;
        acc_addr  <= {base_hi, low_nx};
      end else begin
        acc_valid <= 1'b0;
        acc_wr    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwsram_wbuf.sv
module pwsram_wbuf #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LW    = 8,
  parameter int LANES = DW / LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             cap,
  input  logic [AW-1:0]    cap_addr,
  input  logic [DW-1:0]    cap_data,
  input  logic [LANES-1:0] cap_lane,
  output logic             pend_valid,
  output logic [AW-1:0]    pend_addr,
  output logic [DW-1:0]    pend_data,
  output logic [LANES-1:0] pend_lane,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    arr_word,
  output logic [DW-1:0]    fwd_word
);

  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_lane  <= '0;
    end else if (cen) begin
      pend_valid <= cap;
      if (cap) begin
        pend_addr <= cap_addr;
        pend_data <= cap_data;
        pend_lane <= cap_lane;
      end
    end
  end

  assign hit = pend_valid && (pend_addr == rd_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_merge
    assign fwd_word[i*LW +: LW] = (hit && pend_lane[i]) ? pend_data[i*LW +: LW]
                                                        : arr_word[i*LW +: LW];
  end

endmodule

// File: rtl/pwsram_array.sv
module pwsram_array #(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LW    = 8,
  parameter int LANES = DW / LW
) (
  input  logic             clk,
  input  logic             wen,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wlane,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) begin
      for (int i = 0; i < LANES; i++) begin
        if (wlane[i]) mem[waddr][i*LW +: LW] <= wdata[i*LW +: LW];
      end
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pwsram_top.sv
module pwsram_top #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int LW = 8,
  localparam int LANES = DW / LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             burst_load,
  input  logic             cs0,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic             ilv_order,
  input  logic [LANES-1:0] lane_we,
  input  logic [DW-1:0]    dq_i,
  input  logic             oe,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe
);

  logic             sel;
  logic             acc_valid;
  logic             acc_wr;
  logic [AW-1:0]    acc_addr;
  logic             pend_valid;
  logic [AW-1:0]    pend_addr;
  logic [DW-1:0]    pend_data;
  logic [LANES-1:0] pend_lane;
  logic [DW-1:0]    arr_word;
  logic             cap;
  logic             commit;

  assign sel    = cs0 & cs1 & ~cs2_n;
  assign cap    = acc_valid & acc_wr;
  assign commit = cen & pend_valid;

  pwsram_burst #(.AW(AW)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen       (cen),
    .load      (burst_load),
    .sel       (sel),
    .wr        (wr),
    .addr      (addr),
    .ilv       (ilv_order),
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr)
  );

  pwsram_wbuf #(.AW(AW), .DW(DW), .LW(LW), .LANES(LANES)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen        (cen),
    .cap        (cap),
    .cap_addr   (acc_addr),
    .cap_data   (dq_i),
    .cap_lane   (lane_we),
    .pend_valid (pend_valid),
    .pend_addr  (pend_addr),
    .pend_data  (pend_data),
    .pend_lane  (pend_lane),
    .rd_addr    (acc_addr),
    .arr_word   (arr_word),
    .fwd_word   (dq_o)
  );

  pwsram_array #(.AW(AW), .DW(DW), .LW(LW), .LANES(LANES)) u_array (
    .clk   (clk),
    .wen   (commit),
    .waddr (pend_addr),
    .wdata (pend_data),
    .wlane (pend_lane),
    .raddr (acc_addr),
    .rdata (arr_word)
  );

  assign dq_oe = oe & acc_valid & ~acc_wr;

endmodule

// File: rtl/pwsram_chk.sv
module pwsram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cen,
  input logic          burst_load,
  input logic          cs0,
  input logic          cs1,
  input logic          cs2_n,
  input logic          wr,
  input logic          oe,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe
);

  logic sel_ok;
  assign sel_ok = cs0 && cs1 && !cs2_n;

  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && burst_load && sel_ok && !wr) |=> (dq_oe == oe));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && dq_oe) |=> (!oe || $stable(dq_o)));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && burst_load && !sel_ok) |=> !dq_oe);

  assert_wr_phase_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && burst_load && sel_ok && wr) |=> !dq_oe);

  assert_oe_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_oe);

  assert_adv_after_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cen && burst_load && !sel_ok) ##1 (cen && !burst_load) |=> !dq_oe);

  assert_reset_idle_R12: assert property (@(posedge clk)
    $rose(rst_n) |-> !dq_oe);

endmodule

bind pwsram_top pwsram_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cen        (cen),
  .burst_load (burst_load),
  .cs0        (cs0),
  .cs1        (cs1),
  .cs2_n      (cs2_n),
  .wr         (wr),
  .oe         (oe),
  .dq_o       (dq_o),
  .dq_oe      (dq_oe)
);

// File: tb/pwsram_top_tb.sv
module pwsram_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 32;
  localparam int LANES = 4;
  localparam int DEPTH = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cen = 1'b1;
  logic             burst_load = 1'b1;
  logic             cs0 = 1'b0;
  logic             cs1 = 1'b0;
  logic             cs2_n = 1'b1;
  logic             wr = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             ilv_order = 1'b0;
  logic [LANES-1:0] lane_we = '0;
  logic [DW-1:0]    dq_i = '0;
  logic             oe = 1'b1;
  logic [DW-1:0]    dq_o;
  logic             dq_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [DEPTH];

  int            prev_kind = 0;   // 0 idle, 1 read, 2 write
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_wd = '0;
  logic [3:0]    prev_be = '0;
  string         prev_tag = "R12";

  bit            b_act = 1'b0;
  bit            b_wr = 1'b0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwsram_top #(.AW(AW), .DW(DW), .LW(8)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen        (cen),
    .burst_load (burst_load),
    .cs0        (cs0),
    .cs1        (cs1),
    .cs2_n      (cs2_n),
    .wr         (wr),
    .addr       (addr),
    .ilv_order  (ilv_order),
    .lane_we    (lane_we),
    .dq_i       (dq_i),
    .oe         (oe),
    .dq_o       (dq_o),
    .dq_oe      (dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return (32'(a) * 32'h0100_0193) ^ (32'(s) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input logic [1:0] n, input bit ilv);
    logic [1:0] lo;
    lo = ilv ? (base[1:0] ^ n) : (base[1:0] + n);
    return {base[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks the data phase of the previous command; drives its write data when asked
  task automatic phase_check(input bit drive);
    if (prev_kind == 1) begin
      chk(dq_oe == 1'b1, prev_tag, {31'b0, dq_oe}, 32'd1);
      chk(dq_o == model[prev_addr], prev_tag, dq_o, model[prev_addr]);
    end else begin
      chk(dq_oe == 1'b0, (prev_kind == 2) ? "R5" : prev_tag, {31'b0, dq_oe}, 32'd0);
    end
    if (prev_kind == 2 && drive) begin
      dq_i    = prev_wd;
      lane_we = prev_be;
      for (int i = 0; i < LANES; i++)
        if (prev_be[i]) model[prev_addr][i*8 +: 8] = prev_wd[i*8 +: 8];
    end else begin
      dq_i    = ~pat(prev_addr, 99);
      lane_we = 4'hF;
    end
  endtask

  // csv: 0 all selects good, 1 cs0 low, 2 cs1 low, 3 cs2_n high
  task automatic issue(input bit ld, input int csv, input bit wr_i, input int a,
                       input bit ilv, input logic [DW-1:0] wd, input logic [3:0] be,
                       input string tag);
    @(negedge clk);
    phase_check(1'b1);
    cen        = 1'b1;
    burst_load = ld;
    cs0        = (csv != 1);
    cs1        = (csv != 2);
    cs2_n      = (csv == 3);
    wr         = wr_i;
    addr       = AW'(a);
    ilv_order  = ilv;
    if (ld) begin
      if (csv == 0) begin
        b_act = 1'b1; b_wr = wr_i; b_base = AW'(a); b_cnt = 2'd0;
        prev_kind = wr_i ? 2 : 1;
        prev_addr = AW'(a);
      end else begin
        b_act = 1'b0;
        prev_kind = 0;
      end
    end else if (b_act) begin
      b_cnt = b_cnt + 2'd1;
      prev_kind = b_wr ? 2 : 1;
      prev_addr = beat_addr(b_base, b_cnt, ilv);
    end else begin
      prev_kind = 0;
    end
    prev_wd  = wd;
    prev_be  = be;
    prev_tag = tag;
  endtask

  task automatic stall();
    @(negedge clk);
    phase_check(1'b0);
    cen        = 1'b0;
    burst_load = ~burst_load;
    wr         = ~wr;
    addr       = ~addr;
    cs0        = 1'b1; cs1 = 1'b1; cs2_n = 1'b0;
  endtask

  task automatic oe_probe();
    @(posedge clk);
    #1 oe = 1'b0;
    #1 chk(dq_oe == 1'b0, "R6", {31'b0, dq_oe}, 32'd0);
    oe = 1'b1;
    #1 chk(dq_oe == 1'b1, "R6", {31'b0, dq_oe}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: idle after reset, then an advance stays deselected (R10)
    issue(1'b0, 0, 1'b0, 5, 1'b0, '0, 4'h0, "R10");
    issue(1'b0, 0, 1'b0, 6, 1'b0, '0, 4'h0, "R12");

    // R4/R11: fill every word, full lanes
    for (int a = 0; a < DEPTH; a++) issue(1'b1, 0, 1'b1, a, 1'b0, pat(a, 1), 4'hF, "R4");
    // R1: read every word back to back
    for (int a = 0; a < DEPTH; a++) issue(1'b1, 0, 1'b0, a, 1'b0, '0, 4'h0, "R1");

    // R4/R7/R11: alternate write, read-same (forwarded), read-neighbour; all lane masks
    for (int a = 0; a < DEPTH; a++) begin
      issue(1'b1, 0, 1'b1, a, 1'b0, pat(a, 2), 4'(a), "R4");
      issue(1'b1, 0, 1'b0, a, 1'b0, '0, 4'h0, "R7");
      issue(1'b1, 0, 1'b0, a ^ 1, 1'b0, '0, 4'h0, "R11");
    end

    // R7: two partial writes to one word, then read it
    for (int a = 8; a < 12; a++) begin
      issue(1'b1, 0, 1'b1, a, 1'b0, pat(a, 3), 4'b0011, "R4");
      issue(1'b1, 0, 1'b1, a, 1'b0, pat(a, 4), 4'b1100, "R4");
      issue(1'b1, 0, 1'b0, a, 1'b0, '0, 4'h0, "R7");
      issue(1'b1, 0, 1'b0, a, 1'b0, '0, 4'h0, "R7");
    end

    // R8/R9/R10: every start in both orders, write burst then reads
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        int base;
        base = 40 + s;
        issue(1'b1, 0, 1'b1, base, o[0], pat(base, 10 + o), 4'hF, "R4");
        for (int k = 1; k < 7; k++) begin
          logic [AW-1:0] ad;
          ad = beat_addr(AW'(base), 2'(k), o[0]);
          issue(1'b0, 3, 1'b0, 0, o[0], pat(int'(ad), 10 + o), 4'hF, o ? "R9" : "R8");
        end
        for (int j = 40; j < 44; j++)
          issue(1'b1, 0, 1'b0, j, 1'b0, '0, 4'h0, o ? "R9" : "R8");
        issue(1'b1, 0, 1'b0, base, o[0], '0, 4'h0, "R1");
        for (int k = 1; k < 6; k++)
          issue(1'b0, 1, 1'b1, 0, o[0], '0, 4'h0, "R10");
      end
    end

    // R3/R10: each select missing, then an advance
    for (int v = 1; v < 4; v++) begin
      issue(1'b1, v, 1'b0, 3, 1'b0, '0, 4'h0, "R3");
      issue(1'b0, 0, 1'b0, 3, 1'b0, '0, 4'h0, "R10");
      issue(1'b1, v, 1'b1, 4, 1'b0, pat(4, 7), 4'hF, "R3");
    end
    issue(1'b1, 0, 1'b0, 4, 1'b0, '0, 4'h0, "R3");

    // R2: stall during a write data phase and during a read data phase
    issue(1'b1, 0, 1'b1, 20, 1'b0, pat(20, 8), 4'b0101, "R2");
    stall();
    stall();
    issue(1'b1, 0, 1'b0, 20, 1'b0, '0, 4'h0, "R2");
    stall();
    stall();
    issue(1'b1, 0, 1'b0, 21, 1'b0, '0, 4'h0, "R2");
    issue(1'b1, 0, 1'b0, 20, 1'b0, '0, 4'h0, "R2");

    // R6: output enable pulled low inside a read data phase
    issue(1'b1, 0, 1'b0, 30, 1'b0, '0, 4'h0, "R1");
    oe_probe();
    issue(1'b1, 1, 1'b0, 0, 1'b0, '0, 4'h0, "R3");
    issue(1'b1, 1, 1'b0, 0, 1'b0, '0, 4'h0, "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule